// File: doc/BRIEF.md
# Selectable-Depth Receive Synchronizer

This block conditions an asynchronous serial receive line before the protocol logic uses it. A small configuration word selects one of four paths for the line. The first path is a two-flop synchronizer on the rising clock edge. The second is a rising-edge flop followed by a falling-edge flop. The third is a single rising-edge flop. The fourth is a direct combinational bypass. Deeper paths trade latency for protection against metastability. The falling-edge variant removes half a clock of that latency.

The selection is held in a four-state machine. Its states are `SEL_DPP` (double, both rising), `SEL_DPN` (rising then falling), `SEL_SP` (single rising) and `SEL_BYP` (bypass). Reset enters `SEL_DPP`. The machine has one transition type, the accepted write. On a rising edge where the write strobe is high and the write-protect flag is low, any state moves to the state named by the write data. Codes above 3 map to `SEL_DPP`. Every other edge holds the current state. The selection cannot be read back.

Top module: `rxsync_cond`

## Requirements
- R1: With selection code 0, `rx_out` shows the value `rx_raw` had at the rising edge two edges earlier. It changes only on rising edges.
- R2: With selection code 1, the value `rx_raw` had at a rising edge appears on `rx_out` at the falling edge that follows. It is not visible before that falling edge.
- R3: With selection code 2, `rx_out` shows the value `rx_raw` had at the previous rising edge. It changes on that rising edge.
- R4: With selection code 3, `rx_out` follows `rx_raw` combinationally in the same cycle.
- R5: While `rst_n` is low, `rx_out` is 1 (recessive), whatever `rx_raw` is. After reset the selection is code 0.
- R6: A write with `cfg_we`=1 and `cfg_lock`=0 at a rising edge sets the selection to `cfg_wdata`. `rx_out` takes the new path from that edge on, with no extra cycle.
- R7: A write at a rising edge with `cfg_lock`=1 leaves the selection unchanged. `rx_out` keeps following the previous path.
- R8: An accepted write of any code from 4 to 7 makes the selection behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Stage flops use the rising edge; the mixed path also uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Asynchronous serial receive line |
| cfg_we | input | 1 | Configuration write strobe, sampled on the rising edge |
| cfg_wdata | input | MODE_W (3) | Path selection code: 0 double rising, 1 rising then falling, 2 single, 3 bypass, 4 to 7 as 0 |
| cfg_lock | input | 1 | Write protect; while 1, writes are discarded |
| rx_out | output | 1 | Conditioned receive bit |

## Verification
A path-selection write and a change on the receive line can land on the same rising edge. The bench drives them together on purpose. At that edge a new `rx_raw` value enters the first stage, and the output multiplexer switches to a tap of a different depth. A reference history of the line is kept. For each cycle, the expected bit is taken from that history at the depth of the newly selected path, so an extra cycle of selection latency would pick the wrong historical bit. The bench samples the output twice per cycle, before and after the falling edge. This tells the half-cycle path apart from the single-flop path, and it also covers locked writes issued while the line toggles.

// File: rtl/rxsync_pkg.sv
`timescale 1ns/1ps
package rxsync_pkg;

    localparam int unsigned NUM_PATHS = 4;
    localparam int unsigned PATH_W    = $clog2(NUM_PATHS);

    // Selection state; the encoding equals the accepted write code.
    typedef enum logic [PATH_W-1:0] {
        SEL_DPP = 2'd0,   // two rising-edge stages
        SEL_DPN = 2'd1,   // rising stage, then falling stage
        SEL_SP  = 2'd2,   // one rising-edge stage
        SEL_BYP = 2'd3    // combinational bypass
    } rx_path_e;

endpackage

// File: rtl/rxsync_cfg.sv
`timescale 1ns/1ps
module rxsync_cfg
    import rxsync_pkg::*;
#(
    parameter int unsigned MODE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_lock,
    input  logic [MODE_W-1:0]    wr_code,
    output rx_path_e             path_q,
    output logic [NUM_PATHS-1:0] path_oh
);

    logic     accept;
    logic     code_high;
    rx_path_e target;
    rx_path_e cur_q;
    rx_path_e nxt;

    assign accept = wr_en & ~wr_lock;

    generate
        if (MODE_W > PATH_W) begin : g_wide
            assign code_high = |wr_code[MODE_W-1:PATH_W];
        end else begin : g_narrow
            assign code_high = 1'b0;
        end
    endgenerate

    // Codes beyond the four paths fold onto the double rising path.
    always_comb begin
        if (code_high) begin
            target = SEL_DPP;
        end else begin
            target = rx_path_e'(wr_code[PATH_W-1:0]);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= SEL_DPP;
        end else begin
            cur_q <= nxt;
        end
    end

    // Transitions: every state leaves only on an accepted write
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            SEL_DPP: if (accept) nxt = target;
            SEL_DPN: if (accept) nxt = target;
            SEL_SP:  if (accept) nxt = target;
            SEL_BYP: if (accept) nxt = target;
            default: nxt = SEL_DPP;
        endcase
    end

    // Outputs: one-hot tap select per state
    always_comb begin
        path_oh = '0;
        unique case (cur_q)
            SEL_DPP: path_oh[SEL_DPP] = 1'b1;
            SEL_DPN: path_oh[SEL_DPN] = 1'b1;
            SEL_SP:  path_oh[SEL_SP]  = 1'b1;
            SEL_BYP: path_oh[SEL_BYP] = 1'b1;
            default: path_oh[SEL_DPP] = 1'b1;
        endcase
    end

    assign path_q = cur_q;

endmodule

// File: rtl/rxsync_stages.sv
`timescale 1ns/1ps
module rxsync_stages #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic first_q,
    output logic second_rise_q,
    output logic second_fall_q
);

    // First stage, rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= RST_LVL;
        end else begin
            first_q <= din;
        end
    end

    // Second stage, rising-edge variant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_rise_q <= RST_LVL;
        end else begin
            second_rise_q <= first_q;
        end
    end

    // Second stage, falling-edge variant
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_fall_q <= RST_LVL;
        end else begin
            second_fall_q <= first_q;
        end
    end

endmodule

// File: rtl/rxsync_pathsel.sv
`timescale 1ns/1ps
module rxsync_pathsel
    import rxsync_pkg::*;
(
    input  logic [NUM_PATHS-1:0] sel_oh,
    input  logic [NUM_PATHS-1:0] taps,
    output logic                 dout
);

    logic [NUM_PATHS-1:0] gated;

    generate
        for (genvar i = 0; i < NUM_PATHS; i++) begin : g_tap
            assign gated[i] = sel_oh[i] & taps[i];
        end
    endgenerate

    assign dout = |gated;

endmodule

// File: rtl/rxsync_cond.sv
`timescale 1ns/1ps
module rxsync_cond
    import rxsync_pkg::*;
#(
    parameter int unsigned MODE_W  = 3,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_raw,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              cfg_lock,
    output logic              rx_out
);

    rx_path_e             path_w;
    logic [NUM_PATHS-1:0] sel_oh;
    logic [NUM_PATHS-1:0] taps;
    logic                 st_first;
    logic                 st_rise;
    logic                 st_fall;

    rxsync_cfg #(
        .MODE_W (MODE_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_lock (cfg_lock),
        .wr_code (cfg_wdata),
        .path_q  (path_w),
        .path_oh (sel_oh)
    );

    rxsync_stages #(
        .RST_LVL (RST_LVL)
    ) u_stages (
        .clk           (clk),
        .rst_n         (rst_n),
        .din           (rx_raw),
        .first_q       (st_first),
        .second_rise_q (st_rise),
        .second_fall_q (st_fall)
    );

    // Tap order matches the selection encoding.
    assign taps[SEL_DPP] = st_rise;
    assign taps[SEL_DPN] = st_fall;
    assign taps[SEL_SP]  = st_first;
    assign taps[SEL_BYP] = rx_raw;

    rxsync_pathsel u_sel (
        .sel_oh (sel_oh),
        .taps   (taps),
        .dout   (rx_out)
    );

endmodule

// File: rtl/rxsync_chk.sv
`timescale 1ns/1ps
module rxsync_chk
    import rxsync_pkg::*;
#(
    parameter int unsigned MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_raw,
    input logic              cfg_we,
    input logic [MODE_W-1:0] cfg_wdata,
    input logic              cfg_lock,
    input rx_path_e          path,
    input logic              rx_out
);

    // Edges seen since reset release, saturating at 3
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    logic wr_ok;
    logic wr_big;
    assign wr_ok  = cfg_we & ~cfg_lock;
    assign wr_big = (cfg_wdata > MODE_W'(3));

    p_two_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && path == SEL_DPP) |-> (rx_out == $past(rx_raw, 2)));

    p_mixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && path == SEL_DPN) |-> (rx_out == $past(rx_raw)));

    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && path == SEL_SP) |-> (rx_out == $past(rx_raw)));

    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (path == SEL_BYP) |-> (rx_out == rx_raw));

    p_idle_r5: assert property (@(posedge clk)
        (!rst_n) |-> (rx_out == 1'b1));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !wr_big) |=> (path == rx_path_e'($past(cfg_wdata[1:0]))));

    p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_lock) |=> $stable(path));

    p_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_big) |=> (path == SEL_DPP));

endmodule

bind rxsync_cond rxsync_chk #(.MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_raw    (rx_raw),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_lock  (cfg_lock),
    .path      (path_w),
    .rx_out    (rx_out)
);

// File: tb/rxsync_cond_tb.sv
`timescale 1ns/1ps
module rxsync_cond_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       rx_raw = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'd0;
    logic       cfg_lock = 1'b0;
    logic       rx_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  val;
        string tag;
        string phase;
    } exp_t;

    exp_t sb_q[$];

    // Reference state
    int   mdl_mode = 0;
    logic hist[3] = '{1'b1, 1'b1, 1'b1};   // [0] current, [1] one edge ago, [2] two ago
    logic pend_we = 1'b0;
    logic pend_lock = 1'b0;
    logic [2:0] pend_wd = 3'd0;
    logic [7:0] lfsr = 8'hA5;

    always #2.5 clk = ~clk;   // 200 MHz

    rxsync_cond u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_raw    (rx_raw),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_lock  (cfg_lock),
        .rx_out    (rx_out)
    );

    function automatic logic pick(input int m, input bit late);
        case (m)
            1:       return late ? hist[1] : hist[2];
            2:       return hist[1];
            3:       return hist[0];
            default: return hist[2];
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            1:       return "R2";
            2:       return "R3";
            3:       return "R4";
            default: return "R1";
        endcase
    endfunction

    // Driver: one cycle of stimulus, pushes two expected samples
    task automatic cyc(input logic rx, input logic we, input logic lock, input logic [2:0] wd);
        string tag;
        @(posedge clk);
        tag = mode_tag(mdl_mode);
        if (pend_we) begin
            if (!pend_lock) begin
                mdl_mode = (pend_wd > 3'd3) ? 0 : int'(pend_wd);
                tag = (pend_wd > 3'd3) ? "R8" : "R6";
            end else begin
                tag = "R7";
            end
        end
        #1;
        rx_raw    = rx;
        cfg_we    = we;
        cfg_lock  = lock;
        cfg_wdata = wd;
        pend_we   = we;
        pend_lock = lock;
        pend_wd   = wd;
        hist[2]   = hist[1];
        hist[1]   = hist[0];
        hist[0]   = rx;
        sb_q.push_back('{pick(mdl_mode, 1'b0), tag, "pre-fall"});
        sb_q.push_back('{pick(mdl_mode, 1'b1), tag, "post-fall"});
    endtask

    task automatic run_lfsr(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0], 1'b0, 1'b0, 3'd0);
        end
    endtask

    task automatic run_alt(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(i[0], 1'b0, 1'b0, 3'd0);
        end
    endtask

    task automatic compare_one();
        exp_t e;
        if (sb_q.size() != 0) begin
            e = sb_q.pop_front();
            checks++;
            if (rx_out !== e.val) begin
                fails++;
                $display("FAIL %s (%s): rx_out=%b expected=%b at %0t", e.tag, e.phase, rx_out, e.val, $time);
            end
        end
    endtask

    // Monitor: samples before (+2) and after (+4) the falling edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            compare_one();
            #2;
            compare_one();
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        rx_raw = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        // R5: idle-high output while in reset, line held low
        checks++;
        if (rx_out !== 1'b1) begin
            fails++;
            $display("FAIL R5: rx_out=%b expected=1 during reset", rx_out);
        end
        rx_raw = 1'b1;
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R5/R1: default path after reset is the double rising synchronizer
        run_alt(10);
        run_lfsr(12);

        // R6: select rising-then-falling, line changes in the same cycle
        cyc(1'b0, 1'b1, 1'b0, 3'd1);
        run_lfsr(14);
        run_alt(6);

        // R6: single stage
        cyc(1'b1, 1'b1, 1'b0, 3'd2);
        run_lfsr(14);

        // R6: bypass
        cyc(1'b0, 1'b1, 1'b0, 3'd3);
        run_alt(6);
        run_lfsr(10);

        // R7: locked write of code 2 while bypassing
        cyc(1'b1, 1'b1, 1'b1, 3'd2);
        run_lfsr(10);

        // R8: code 5 behaves as code 0
        cyc(1'b0, 1'b1, 1'b0, 3'd5);
        run_lfsr(12);

        // R7: locked write of code 3 while in the default path
        cyc(1'b1, 1'b1, 1'b1, 3'd3);
        run_alt(8);

        // R6 then R8: select mixed, then code 7 back to double rising
        cyc(1'b1, 1'b1, 1'b0, 3'd1);
        run_lfsr(6);
        cyc(1'b0, 1'b1, 1'b0, 3'd7);
        run_lfsr(10);

        // R6: back-to-back writes on consecutive edges
        cyc(1'b1, 1'b1, 1'b0, 3'd3);
        cyc(1'b0, 1'b1, 1'b0, 3'd2);
        cyc(1'b1, 1'b1, 1'b0, 3'd4);
        run_lfsr(8);

        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_up();
    end

endmodule